// File: doc/BRIEF.md
# Single-Cell Battery Protection State Controller

This block decides, one time-base tick at a time, whether a single-cell battery pack may charge and whether it may discharge. It takes flags that analog comparators have already digitized: cell voltage against the over-charge level and against that level minus hysteresis, cell voltage against the under-voltage level, and the current-sense node against the discharge over-current, short-circuit, charge over-current and deep-negative levels. From these flags it drives a charge-switch enable, a discharge-switch enable and a 3-bit state code.

Each fault has its own qualification window, counted in ticks of a prescaled time base, and its own release rule. A fault is recognised only when its condition holds without a break for the whole window. The controller holds one state at a time. Every fault returns to the normal state, and no fault state moves straight to another. A 2-bit model-select input picks the charge over-current window. The window becomes shorter while the sense node is deeply negative.

Top module: `batt_guard_ctrl`

## Requirements
- R1: After a synchronous active-low reset the state code is 0 (normal) and both enables are 1.
- R2: State codes are 0 normal, 1 discharge over-current, 2 short circuit, 3 charge over-current, 4 over-charge. The charge enable is 0 only in codes 3 and 4. The discharge enable is 0 only in codes 1 and 2.
- R3: In normal, if sense_ge_doc is 1 and sense_ge_short is 0 on T_DOC consecutive ticks, the state becomes 1 one clock after the last of those ticks.
- R4: In normal, if sense_ge_short is 1 on T_SHORT consecutive ticks, the state becomes 2.
- R5: From states 1 and 2, sense_ge_doc at 0 on T_REL1 consecutive ticks returns the state to 0.
- R6: In normal, if sense_lt_coc is 1 on the selected number of consecutive ticks, the state becomes 3. The window is selected by model_sel: 0 gives T_COC_FAST, 1 gives T_COC_MID, and 2 or 3 give T_COC_SLOW.
- R7: While sense_le_deep is 1, the charge over-current window is T_COC_FAST for model 0, T_COC_MID_DEEP for model 1, and T_COC_SLOW_DEEP for models 2 and 3.
- R8: From state 3, sense_lt_coc at 0 on T_REL1 consecutive ticks returns the state to 0.
- R9: In normal, if cell_ge_ovc is 1 on T_OVC consecutive ticks, the state becomes 4.
- R10: From state 4, cell_le_hyst at 1 on T_REL2 consecutive ticks returns the state to 0.
- R11: From state 4, sense_ge_doc at 1 with cell_ge_ovc at 0 on T_REL2 consecutive ticks returns the state to 0. While cell_ge_ovc stays 1, a load alone never releases state 4, and the discharge enable stays 1.
- R12: A qualification or release count restarts from zero whenever its condition is false on any clock. A window is met only by an unbroken run of ticks.
- R13: When several entry windows complete on the same tick, the order of priority is short circuit, then discharge over-current, then charge over-current, then over-charge.
- R14: While cell_above_uv is 0, no fault is entered from the normal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse from the prescaled time base |
| model_sel | input | 2 | Selects the charge over-current window |
| cell_above_uv | input | 1 | Cell voltage is above the under-voltage level |
| cell_ge_ovc | input | 1 | Cell voltage is at or above the over-charge level |
| cell_le_hyst | input | 1 | Cell voltage is at or below the over-charge level minus hysteresis |
| sense_ge_doc | input | 1 | Sense node is at or above the discharge over-current level |
| sense_ge_short | input | 1 | Sense node is at or above the short-circuit level |
| sense_lt_coc | input | 1 | Sense node is below the charge over-current level |
| sense_le_deep | input | 1 | Sense node is at or below the deep-negative level |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| state_code | output | 3 | Current state code |

## Verification
Every fault is driven with hold lengths from one tick up to one tick past its window, and a trip is expected only when the hold reaches the window. For each trip the release is counted to the tick before the window and then to the window, which separates an off-by-one in either direction. The charge over-current sweep runs over every model code with the deep-negative flag low and high, which shows that the window is chosen correctly. Further sequences put a gap in a hold, break a release run, fire two windows on the same tick, hold a load on an over-charged cell and clear the under-voltage flag. Each of these separates correct counter restarts, correct priority and correct gating from a design that only counts total ticks.

// File: rtl/batt_guard_pkg.sv
// Shared types for the battery protection controller.
// Assumes: state codes are visible at the top-level port and must stay stable.
package batt_guard_pkg;

    typedef enum logic [2:0] {
        ST_NORMAL = 3'd0,
        ST_DSG_OC = 3'd1,
        ST_SHORT  = 3'd2,
        ST_CHG_OC = 3'd3,
        ST_OVCHG  = 3'd4
    } guard_state_t;

    // Index of each entry timer. A lower index has higher priority.
    localparam int unsigned IDX_SHORT  = 0;
    localparam int unsigned IDX_DSG_OC = 1;
    localparam int unsigned IDX_CHG_OC = 2;
    localparam int unsigned IDX_OVCHG  = 3;
    localparam int unsigned N_ENTRY    = 4;

endpackage

// File: rtl/qual_timer.sv
// Qualification timer. It counts ticks while cond holds and clears on any
// clock where cond is false. fire is asserted on the tick that completes
// `limit` consecutive qualifying ticks.
// Assumes: limit >= 1, and limit may change while counting (deep-negative switch).
module qual_timer #(
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          cond,
    input  logic [CW-1:0] limit,
    output logic          fire
);
    localparam logic [CW-1:0] CNT_MAX = '1;

    logic [CW-1:0] cnt_q;
    logic          reached;

    // Compare the count including the current tick against the window.
    always_comb begin
        reached = ({1'b0, cnt_q} + {{CW{1'b0}}, 1'b1}) >= {1'b0, limit};
        fire    = cond && tick && reached;
    end

    // Count qualifying ticks, restart on any break, saturate at the top.
    always_ff @(posedge clk) begin
        if (!rst_n || !cond) begin
            cnt_q <= '0;
        end else if (tick && !fire && cnt_q != CNT_MAX) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R12: a break in the condition clears the run
    a_r12_break_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !cond |=> (cnt_q == '0));

    // R12: the count moves only on a tick
    a_r12_count_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (cond && !tick) |=> $stable(cnt_q));

endmodule

// File: rtl/coc_window_sel.sv
// Selects the charge over-current qualification window from the model code
// and the deep-negative flag.
// Assumes: model code 3 is treated the same as code 2.
module coc_window_sel #(
    parameter int unsigned CW               = 16,
    parameter int unsigned T_COC_FAST       = 8,
    parameter int unsigned T_COC_MID        = 125,
    parameter int unsigned T_COC_SLOW       = 1000,
    parameter int unsigned T_COC_MID_DEEP   = 7,
    parameter int unsigned T_COC_SLOW_DEEP  = 56
) (
    input  logic [1:0]    model_sel,
    input  logic          deep_neg,
    output logic [CW-1:0] window
);
    localparam logic [CW-1:0] W_FAST      = CW'(T_COC_FAST);
    localparam logic [CW-1:0] W_MID       = CW'(T_COC_MID);
    localparam logic [CW-1:0] W_SLOW      = CW'(T_COC_SLOW);
    localparam logic [CW-1:0] W_MID_DEEP  = CW'(T_COC_MID_DEEP);
    localparam logic [CW-1:0] W_SLOW_DEEP = CW'(T_COC_SLOW_DEEP);

    // Choose the window. The fast model keeps its window when deeply negative.
    always_comb begin
        unique case (model_sel)
            2'd0:    window = W_FAST;
            2'd1:    window = deep_neg ? W_MID_DEEP : W_MID;
            default: window = deep_neg ? W_SLOW_DEEP : W_SLOW;
        endcase
    end

endmodule

// File: rtl/batt_guard_ctrl.sv
// Battery protection state controller. It qualifies each fault over its own
// window of time-base ticks, holds one state at a time, and drives the charge
// and discharge switch enables.
// Assumes: comparator flags are already synchronized to clk, and tick is a
// single-clock pulse.
module batt_guard_ctrl
    import batt_guard_pkg::*;
#(
    parameter int unsigned CW              = 16,
    parameter int unsigned T_SHORT         = 1,
    parameter int unsigned T_DOC           = 12,
    parameter int unsigned T_COC_FAST      = 8,
    parameter int unsigned T_COC_MID       = 125,
    parameter int unsigned T_COC_SLOW      = 1000,
    parameter int unsigned T_COC_MID_DEEP  = 7,
    parameter int unsigned T_COC_SLOW_DEEP = 56,
    parameter int unsigned T_OVC           = 1000,
    parameter int unsigned T_REL1          = 2,
    parameter int unsigned T_REL2          = 30
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] model_sel,
    input  logic       cell_above_uv,
    input  logic       cell_ge_ovc,
    input  logic       cell_le_hyst,
    input  logic       sense_ge_doc,
    input  logic       sense_ge_short,
    input  logic       sense_lt_coc,
    input  logic       sense_le_deep,
    output logic       chg_en,
    output logic       dsg_en,
    output logic [2:0] state_code
);
    localparam logic [CW-1:0] W_SHORT = CW'(T_SHORT);
    localparam logic [CW-1:0] W_DOC   = CW'(T_DOC);
    localparam logic [CW-1:0] W_OVC   = CW'(T_OVC);
    localparam logic [CW-1:0] W_REL1  = CW'(T_REL1);
    localparam logic [CW-1:0] W_REL2  = CW'(T_REL2);

    guard_state_t          state_q, state_d;
    logic                  entry_ok;
    logic [N_ENTRY-1:0]    entry_cond;
    logic [N_ENTRY-1:0]    entry_fire;
    logic [CW-1:0]         entry_lim [N_ENTRY];
    logic [CW-1:0]         coc_window;
    logic                  rel_cond;
    logic [CW-1:0]         rel_lim;
    logic                  rel_fire;

    coc_window_sel #(
        .CW              (CW),
        .T_COC_FAST      (T_COC_FAST),
        .T_COC_MID       (T_COC_MID),
        .T_COC_SLOW      (T_COC_SLOW),
        .T_COC_MID_DEEP  (T_COC_MID_DEEP),
        .T_COC_SLOW_DEEP (T_COC_SLOW_DEEP)
    ) coc_sel_i (
        .model_sel (model_sel),
        .deep_neg  (sense_le_deep),
        .window    (coc_window)
    );

    // Entry conditions. They count only in normal while the cell is above under-voltage.
    always_comb begin
        entry_ok = (state_q == ST_NORMAL) && cell_above_uv;
        entry_cond[IDX_SHORT]  = entry_ok && sense_ge_short;
        entry_cond[IDX_DSG_OC] = entry_ok && sense_ge_doc && !sense_ge_short;
        entry_cond[IDX_CHG_OC] = entry_ok && sense_lt_coc;
        entry_cond[IDX_OVCHG]  = entry_ok && cell_ge_ovc;
        entry_lim[IDX_SHORT]   = W_SHORT;
        entry_lim[IDX_DSG_OC]  = W_DOC;
        entry_lim[IDX_CHG_OC]  = coc_window;
        entry_lim[IDX_OVCHG]   = W_OVC;
    end

    // One qualification timer per fault.
    for (genvar g = 0; g < N_ENTRY; g++) begin : g_entry
        qual_timer #(.CW(CW)) entry_tmr_i (
            .clk   (clk),
            .rst_n (rst_n),
            .tick  (tick),
            .cond  (entry_cond[g]),
            .limit (entry_lim[g]),
            .fire  (entry_fire[g])
        );
    end

    // Release condition and window for the fault now held.
    always_comb begin
        rel_cond = 1'b0;
        rel_lim  = W_REL1;
        unique case (state_q)
            ST_DSG_OC, ST_SHORT: rel_cond = !sense_ge_doc;
            ST_CHG_OC:           rel_cond = !sense_lt_coc;
            ST_OVCHG: begin
                rel_cond = cell_le_hyst || (sense_ge_doc && !cell_ge_ovc);
                rel_lim  = W_REL2;
            end
            default:             rel_cond = 1'b0;
        endcase
    end

    // A single release timer. It is cleared in normal, so it starts fresh for each fault.
    qual_timer #(.CW(CW)) rel_tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (tick),
        .cond  (rel_cond),
        .limit (rel_lim),
        .fire  (rel_fire)
    );

    // Next state: priority among the entry timers, release back to normal.
    always_comb begin
        state_d = state_q;
        if (state_q == ST_NORMAL) begin
            if      (entry_fire[IDX_SHORT])  state_d = ST_SHORT;
            else if (entry_fire[IDX_DSG_OC]) state_d = ST_DSG_OC;
            else if (entry_fire[IDX_CHG_OC]) state_d = ST_CHG_OC;
            else if (entry_fire[IDX_OVCHG])  state_d = ST_OVCHG;
        end else if (rel_fire) begin
            state_d = ST_NORMAL;
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_NORMAL;
        else        state_q <= state_d;
    end

    // Decode the enables and the state code.
    always_comb begin
        chg_en     = !(state_q == ST_CHG_OC || state_q == ST_OVCHG);
        dsg_en     = !(state_q == ST_DSG_OC || state_q == ST_SHORT);
        state_code = state_q;
    end

    // R2: the two enables are never both off
    a_r2_one_enable_on: assert property (@(posedge clk) disable iff (!rst_n)
        chg_en || dsg_en);

    // R2: the state code stays within the defined codes
    a_r2_code_valid: assert property (@(posedge clk) disable iff (!rst_n)
        state_code <= 3'd4);

    // R5: a fault state leaves only toward normal
    a_r5_exit_to_normal: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_NORMAL) |=> (state_q == $past(state_q) || state_q == ST_NORMAL));

    // R12: the state changes only on a tick
    a_r12_state_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(state_q));

    // R14: no fault is entered while the cell is below the under-voltage level
    a_r14_uv_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_NORMAL && !cell_above_uv) |=> state_q == ST_NORMAL);

    // R11: the discharge path stays on in over-charge
    a_r11_ovchg_dsg_on: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OVCHG) |-> dsg_en);

endmodule

// File: tb/batt_guard_ctrl_tb_top.sv
module batt_guard_ctrl_tb_top;

    localparam int T_SHORT = 2;
    localparam int T_DOC   = 4;
    localparam int T_OVC   = 4;
    localparam int T_REL1  = 3;
    localparam int T_REL2  = 5;
    localparam int C_FAST  = 3;
    localparam int C_MID   = 8;
    localparam int C_SLOW  = 12;
    localparam int C_MID_D = 2;
    localparam int C_SLOW_D = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [1:0] model_sel = 2'd0;
    logic       cell_above_uv = 1'b1;
    logic       cell_ge_ovc = 1'b0;
    logic       cell_le_hyst = 1'b0;
    logic       sense_ge_doc = 1'b0;
    logic       sense_ge_short = 1'b0;
    logic       sense_lt_coc = 1'b0;
    logic       sense_le_deep = 1'b0;
    logic       chg_en, dsg_en;
    logic [2:0] state_code;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    batt_guard_ctrl #(
        .CW(8), .T_SHORT(T_SHORT), .T_DOC(T_DOC),
        .T_COC_FAST(C_FAST), .T_COC_MID(C_MID), .T_COC_SLOW(C_SLOW),
        .T_COC_MID_DEEP(C_MID_D), .T_COC_SLOW_DEEP(C_SLOW_D),
        .T_OVC(T_OVC), .T_REL1(T_REL1), .T_REL2(T_REL2)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .model_sel(model_sel),
        .cell_above_uv(cell_above_uv), .cell_ge_ovc(cell_ge_ovc),
        .cell_le_hyst(cell_le_hyst), .sense_ge_doc(sense_ge_doc),
        .sense_ge_short(sense_ge_short), .sense_lt_coc(sense_lt_coc),
        .sense_le_deep(sense_le_deep), .chg_en(chg_en), .dsg_en(dsg_en),
        .state_code(state_code)
    );

    task automatic clear_flags();
        cell_above_uv = 1'b1; cell_ge_ovc = 1'b0; cell_le_hyst = 1'b0;
        sense_ge_doc = 1'b0; sense_ge_short = 1'b0; sense_lt_coc = 1'b0;
        sense_le_deep = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; tick = 1'b0; clear_flags();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
            @(negedge clk);
        end
    endtask

    // Compare the state and both enables with values derived from the code (R2).
    task automatic chk_state(input string tag, input int exp_code);
        logic exp_chg, exp_dsg;
        exp_chg = !(exp_code == 3 || exp_code == 4);
        exp_dsg = !(exp_code == 1 || exp_code == 2);
        checks++;
        if (state_code !== 3'(exp_code) || chg_en !== exp_chg || dsg_en !== exp_dsg) begin
            errors++;
            $display("FAIL %s: actual code=%0d chg=%0b dsg=%0b expected code=%0d chg=%0b dsg=%0b",
                     tag, state_code, chg_en, dsg_en, exp_code, exp_chg, exp_dsg);
        end
    endtask

    // Apply the entry condition of a fault: 0 short, 1 dsg oc, 2 chg oc, 3 over-charge.
    task automatic set_fault(input int which, input bit deep);
        case (which)
            0: begin sense_ge_doc = 1'b1; sense_ge_short = 1'b1; end
            1: sense_ge_doc = 1'b1;
            2: begin sense_lt_coc = 1'b1; sense_le_deep = deep; end
            default: cell_ge_ovc = 1'b1;
        endcase
    endtask

    function automatic int code_of(input int which);
        case (which)
            0: return 2;
            1: return 1;
            2: return 3;
            default: return 4;
        endcase
    endfunction

    // Hold a fault for 1..lim+1 ticks. A trip is expected only when the hold reaches lim.
    // Each trip is then released and checked just before and at the release window.
    task automatic sweep(input string tag, input string rtag, input int which,
                         input bit deep, input int lim, input int rel);
        for (int len = 1; len <= lim + 1; len++) begin
            do_reset();
            set_fault(which, deep);
            ticks(len);
            clear_flags();
            @(negedge clk);
            chk_state(tag, (len >= lim) ? code_of(which) : 0);
            if (len >= lim) begin
                if (which == 3) cell_le_hyst = 1'b1;
                ticks(rel - 1);
                chk_state(rtag, code_of(which));
                ticks(1);
                chk_state(rtag, 0);
            end
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R1 watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        do_reset();
        chk_state("R1 reset state", 0);

        sweep("R4 short trip", "R5 short release", 0, 1'b0, T_SHORT, T_REL1);
        sweep("R3 dsg oc trip", "R5 dsg oc release", 1, 1'b0, T_DOC, T_REL1);
        sweep("R9 over-charge trip", "R10 hysteresis release", 3, 1'b0, T_OVC, T_REL2);

        model_sel = 2'd0;
        sweep("R6 coc model0", "R8 coc release", 2, 1'b0, C_FAST, T_REL1);
        sweep("R7 coc model0 deep", "R8 coc release", 2, 1'b1, C_FAST, T_REL1);
        model_sel = 2'd1;
        sweep("R6 coc model1", "R8 coc release", 2, 1'b0, C_MID, T_REL1);
        sweep("R7 coc model1 deep", "R8 coc release", 2, 1'b1, C_MID_D, T_REL1);
        model_sel = 2'd2;
        sweep("R6 coc model2", "R8 coc release", 2, 1'b0, C_SLOW, T_REL1);
        sweep("R7 coc model2 deep", "R8 coc release", 2, 1'b1, C_SLOW_D, T_REL1);
        model_sel = 2'd3;
        sweep("R6 coc model3", "R8 coc release", 2, 1'b0, C_SLOW, T_REL1);
        sweep("R7 coc model3 deep", "R8 coc release", 2, 1'b1, C_SLOW_D, T_REL1);
        model_sel = 2'd0;

        // R12: a one-tick gap restarts the entry run
        do_reset();
        sense_ge_doc = 1'b1; ticks(T_DOC - 1);
        sense_ge_doc = 1'b0; ticks(1);
        sense_ge_doc = 1'b1; ticks(T_DOC - 1);
        chk_state("R12 entry gap restarts", 0);
        ticks(1);
        chk_state("R12 entry after full run", 1);

        // R12: a broken release run restarts
        sense_ge_doc = 1'b0; ticks(T_REL1 - 1);
        sense_ge_doc = 1'b1; ticks(1);
        sense_ge_doc = 1'b0; ticks(T_REL1 - 1);
        chk_state("R12 release gap restarts", 1);
        ticks(1);
        chk_state("R12 release after full run", 0);

        // R13: discharge over-current wins over over-charge on the same tick
        do_reset();
        sense_ge_doc = 1'b1; cell_ge_ovc = 1'b1;
        ticks(T_DOC);
        clear_flags(); @(negedge clk);
        chk_state("R13 dsg oc over over-charge", 1);

        // R13: charge over-current wins over over-charge (model 1 deep window equals 2)
        do_reset();
        model_sel = 2'd1;
        ticks(0);
        sense_lt_coc = 1'b1; sense_le_deep = 1'b1; cell_ge_ovc = 1'b1;
        ticks(T_OVC);
        clear_flags(); @(negedge clk);
        chk_state("R13 coc over over-charge", 3);
        model_sel = 2'd0;

        // R14: under-voltage blocks entry
        do_reset();
        cell_above_uv = 1'b0; sense_ge_doc = 1'b1; sense_ge_short = 1'b1;
        sense_lt_coc = 1'b0; cell_ge_ovc = 1'b1;
        ticks(T_OVC + 2);
        chk_state("R14 uv blocks short and over-charge", 0);
        clear_flags(); cell_above_uv = 1'b0; sense_lt_coc = 1'b1;
        ticks(C_FAST + 2);
        chk_state("R14 uv blocks coc", 0);

        // R11: with a load and the cell still high, over-charge holds and discharge stays on
        do_reset();
        cell_ge_ovc = 1'b1; ticks(T_OVC);
        chk_state("R9 over-charge entry", 4);
        sense_ge_doc = 1'b1;
        ticks(T_REL2 + 3);
        chk_state("R11 load with high cell holds", 4);
        cell_ge_ovc = 1'b0;
        ticks(T_REL2 - 1);
        chk_state("R11 load release pending", 4);
        ticks(1);
        chk_state("R11 load release", 0);

        // R11: the load path alone, with the cell below the over-charge level from the start
        do_reset();
        cell_ge_ovc = 1'b1; ticks(T_OVC);
        cell_ge_ovc = 1'b0; sense_ge_doc = 1'b1;
        ticks(T_REL2 - 1);
        chk_state("R11 direct load pending", 4);
        ticks(1);
        chk_state("R11 direct load release", 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule